// File: doc/BRIEF.md
# Flash Erase-Block Page-State Tracker

This block keeps the lifecycle state of every page in a small group of flash erase blocks. It also models how long each flash operation keeps the array occupied. A controller sends it commands: read, program, erase, and invalidate. Invalidate marks a page whose data has been moved elsewhere, either by an out-of-place update or by a merge copy. The block checks each command against the current page state. It updates the state only when the command is legal, keeps a per-block wear count, and holds the array busy for a parameterised number of cycles per operation.

A separate query port returns three values with no added latency: the state of any page, the number of valid pages in any block, and that block's wear count. A garbage-collection or wear-levelling engine can therefore pick victims without walking the array. Page data, error-correction bytes and spare-area contents are not held; only state and timing are modelled.

Top module: `flash_page_tracker`

## Requirements
- R1: After reset every page reads free, every valid count and wear count is zero, `busy_o` is low and `cmd_ready_o` is high.
- R2: A program (`cmd_op_i` = 2'b01) to an in-range free page makes it valid and raises that block's valid count by one. It holds `busy_o` for PG_CYC cycles.
- R3: A program to a page that is not free raises `err_o` and changes no page state, no count and no busy.
- R4: Invalidate (`cmd_op_i` = 2'b11) on a valid page makes it invalid and lowers the block's valid count by one, with no busy time. Invalidate on a page that is not valid is an error with no effect.
- R5: Erase (`cmd_op_i` = 2'b10) of an in-range block returns all its pages to free, sets its valid count to zero and raises its wear count by one. The wear count saturates at 2^WEAR_W-1. Erase ignores the page field and holds `busy_o` for ER_CYC cycles.
- R6: Read (`cmd_op_i` = 2'b00) of an in-range page in any state changes no state and holds `busy_o` for RD_CYC cycles.
- R7: A block index of NUM_BLKS or more, or a page index of PAGES or more (except on erase), makes any command an error with no effect.
- R8: A command is accepted on a clock edge with `cmd_valid_i` and `cmd_ready_o` both high; `cmd_ready_o` is the inverse of `busy_o`. Busy time starts in the cycle after acceptance. `err_o` is high for exactly the one cycle after a rejected command, and a rejected command adds no busy time.
- R9: The query outputs are combinational. The page-state encoding is 2'b00 free, 2'b01 valid, 2'b10 invalid. An out-of-range query block or page returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_op_i | input | 2 | 00 read, 01 program, 10 erase, 11 invalidate |
| cmd_blk_i | input | BLK_W (2) | Command block index |
| cmd_page_i | input | PG_W (3) | Command page index |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | One-cycle pulse for a rejected command |
| q_blk_i | input | BLK_W (2) | Query block index |
| q_page_i | input | PG_W (3) | Query page index |
| q_state_o | output | 2 | State of the queried page |
| q_vcnt_o | output | CNT_W (3) | Valid pages in the queried block |
| q_wear_o | output | WEAR_W (8) | Erase count of the queried block |

## Verification
A wrong page state becomes visible as soon as the next command touches that page. A program is then wrongly accepted or refused, which shows up in `err_o` and `busy_o` one cycle after the handshake. The same wrong state can also be read at once on the query port. A drifting valid count or wear count has no effect on command legality, so the bench sweeps every block and page through the query port after each phase of stimulus. Wrong busy time is caught by counting the busy cycles after every accepted command.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_INVAL = 2'b11
  } op_e;

  localparam logic [1:0] PG_FREE    = 2'b00;
  localparam logic [1:0] PG_VALID   = 2'b01;
  localparam logic [1:0] PG_INVALID = 2'b10;
endpackage

// File: rtl/fpt_timer.sv
module fpt_timer #(
  parameter int TMR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             busy_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TMR_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R8
  no_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/fpt_blk.sv
module fpt_blk
  import fpt_pkg::*;
#(
  parameter int PAGES  = 6,
  parameter int WEAR_W = 8,
  localparam int PG_W  = $clog2(PAGES + 1),
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  op_e               op_i,
  input  logic [PG_W-1:0]   page_i,
  output logic [1:0]        cmd_state_o,
  input  logic [PG_W-1:0]   q_page_i,
  output logic [1:0]        q_state_o,
  output logic [CNT_W-1:0]  vcnt_o,
  output logic [WEAR_W-1:0] wear_o
);
  localparam logic [PG_W-1:0]   PG_LIM   = PG_W'(PAGES);
  localparam logic [WEAR_W-1:0] WEAR_MAX = '1;

  logic [1:0]        st_q [PAGES];
  logic [CNT_W-1:0]  vcnt_q;
  logic [WEAR_W-1:0] wear_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGES; i++) st_q[i] <= PG_FREE;
      vcnt_q <= '0;
      wear_q <= '0;
    end else if (we_i) begin
      unique case (op_i)
        OP_PROG: begin
          st_q[page_i] <= PG_VALID;
          vcnt_q       <= vcnt_q + CNT_W'(1);
        end
        OP_INVAL: begin
          st_q[page_i] <= PG_INVALID;
          vcnt_q       <= vcnt_q - CNT_W'(1);
        end
        OP_ERASE: begin
          for (int i = 0; i < PAGES; i++) st_q[i] <= PG_FREE;
          vcnt_q <= '0;
          if (wear_q != WEAR_MAX) wear_q <= wear_q + WEAR_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign cmd_state_o = (page_i < PG_LIM) ? st_q[page_i] : PG_FREE;
  assign q_state_o   = (q_page_i < PG_LIM) ? st_q[q_page_i] : PG_FREE;
  assign vcnt_o      = vcnt_q;
  assign wear_o      = wear_q;

  // R3
  prog_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_PROG) |-> cmd_state_o == PG_FREE);
  // R2
  prog_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_PROG) |=> vcnt_q == $past(vcnt_q) + CNT_W'(1));
  // R5
  erase_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_ERASE) |=> vcnt_q == '0);
  // R5
  wear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_ERASE && wear_q != WEAR_MAX) |=> wear_q == $past(wear_q) + WEAR_W'(1));
  // R4
  vcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcnt_q <= CNT_W'(PAGES));
endmodule

// File: rtl/flash_page_tracker.sv
module flash_page_tracker
  import fpt_pkg::*;
#(
  parameter int NUM_BLKS = 3,
  parameter int PAGES    = 6,
  parameter int WEAR_W   = 8,
  parameter int RD_CYC   = 3,
  parameter int PG_CYC   = 9,
  parameter int ER_CYC   = 34,
  localparam int BLK_W   = $clog2(NUM_BLKS + 1),
  localparam int PG_W    = $clog2(PAGES + 1),
  localparam int CNT_W   = $clog2(PAGES + 1),
  localparam int TMR_W   = $clog2(ER_CYC + RD_CYC + PG_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [BLK_W-1:0]  cmd_blk_i,
  input  logic [PG_W-1:0]   cmd_page_i,
  output logic              busy_o,
  output logic              err_o,
  input  logic [BLK_W-1:0]  q_blk_i,
  input  logic [PG_W-1:0]   q_page_i,
  output logic [1:0]        q_state_o,
  output logic [CNT_W-1:0]  q_vcnt_o,
  output logic [WEAR_W-1:0] q_wear_o
);
  localparam logic [BLK_W-1:0] BLK_LIM = BLK_W'(NUM_BLKS);
  localparam logic [PG_W-1:0]  PG_LIM  = PG_W'(PAGES);

  op_e               op;
  logic              accept, blk_ok, pg_ok, legal, err_q;
  logic [1:0]        cur_st;
  logic [TMR_W-1:0]  lat;
  logic [1:0]        cmd_st  [NUM_BLKS];
  logic [1:0]        q_st    [NUM_BLKS];
  logic [CNT_W-1:0]  vcnt    [NUM_BLKS];
  logic [WEAR_W-1:0] wear    [NUM_BLKS];

  assign op          = op_e'(cmd_op_i);
  assign cmd_ready_o = ~busy_o;
  assign accept      = cmd_valid_i & cmd_ready_o;
  assign blk_ok      = cmd_blk_i < BLK_LIM;
  assign pg_ok       = cmd_page_i < PG_LIM;
  assign cur_st      = blk_ok ? cmd_st[cmd_blk_i] : PG_FREE;

  always_comb begin
    legal = 1'b0;
    lat   = '0;
    unique case (op)
      OP_READ:  begin legal = blk_ok & pg_ok;                         lat = TMR_W'(RD_CYC); end
      OP_PROG:  begin legal = blk_ok & pg_ok & (cur_st == PG_FREE);  lat = TMR_W'(PG_CYC); end
      OP_INVAL: begin legal = blk_ok & pg_ok & (cur_st == PG_VALID); lat = '0;             end
      OP_ERASE: begin legal = blk_ok;                                 lat = TMR_W'(ER_CYC); end
      default: ;
    endcase
  end

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    logic we;
    assign we = accept & legal & (op != OP_READ) & (cmd_blk_i == BLK_W'(b));
    fpt_blk #(.PAGES(PAGES), .WEAR_W(WEAR_W)) u_blk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (we),
      .op_i        (op),
      .page_i      (cmd_page_i),
      .cmd_state_o (cmd_st[b]),
      .q_page_i    (q_page_i),
      .q_state_o   (q_st[b]),
      .vcnt_o      (vcnt[b]),
      .wear_o      (wear[b])
    );
  end

  fpt_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept & legal),
    .val_i  (lat),
    .busy_o (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept & ~legal;
  end
  assign err_o = err_q;

  always_comb begin
    q_state_o = PG_FREE;
    q_vcnt_o  = '0;
    q_wear_o  = '0;
    if (q_blk_i < BLK_LIM) begin
      q_state_o = q_st[q_blk_i];
      q_vcnt_o  = vcnt[q_blk_i];
      q_wear_o  = wear[q_blk_i];
    end
  end

  // R7
  err_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i && cmd_ready_o));
  // R9
  state_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_state_o != 2'b11);
endmodule

// File: tb/sim_flash_page_tracker.sv
module sim_flash_page_tracker;
  localparam int NB = 3, NP = 6, WW = 8, RD = 3, PG = 9, ER = 34;
  localparam int WMAX = (1 << WW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_blk = '0, q_blk = '0;
  logic [2:0] cmd_page = '0, q_page = '0;
  logic cmd_ready, busy, err;
  logic [1:0] q_state;
  logic [2:0] q_vcnt;
  logic [7:0] q_wear;

  int n_chk = 0, n_bad = 0;
  int mst [NB][NP];
  int mvc [NB];
  int mwr [NB];

  always #4 clk = ~clk;

  flash_page_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_blk_i(cmd_blk), .cmd_page_i(cmd_page),
    .busy_o(busy), .err_o(err), .q_blk_i(q_blk), .q_page_i(q_page),
    .q_state_o(q_state), .q_vcnt_o(q_vcnt), .q_wear_o(q_wear));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 8; p++) begin
        int es, ev, ew;
        q_blk = b[1:0]; q_page = p[2:0];
        #1;
        es = (b < NB && p < NP) ? mst[b][p] : 0;
        ev = (b < NB) ? mvc[b] : 0;
        ew = (b < NB) ? mwr[b] : 0;
        chk(q_state == es[1:0], {req, " state"}, q_state, es);
        chk(q_vcnt == ev[2:0], {req, " vcnt"}, q_vcnt, ev);
        chk(q_wear == ew[7:0], {req, " wear"}, q_wear, ew);
      end
  endtask

  // op: 0 read, 1 program, 2 erase, 3 invalidate
  task automatic issue(input int op, input int b, input int p, input string req);
    bit legal;
    int lat, n;
    bit bok = b < NB, pok = p < NP;
    case (op)
      0: begin legal = bok && pok; lat = RD; end
      1: begin legal = bok && pok && mst[b][p] == 0; lat = PG; end
      2: begin legal = bok; lat = ER; end
      default: begin legal = bok && pok && mst[b][p] == 1; lat = 0; end
    endcase
    if (!legal) lat = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_blk = b[1:0]; cmd_page = p[2:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err == !legal, {req, " err"}, err, !legal);
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    if (n == 0) @(negedge clk);
    chk(err == 1'b0, {req, " err pulse"}, err, 0);
    chk(n == lat, {req, " busy cycles"}, n, lat);
    if (legal)
      case (op)
        1: begin mst[b][p] = 1; mvc[b]++; end
        3: begin mst[b][p] = 2; mvc[b]--; end
        2: begin
          for (int i = 0; i < NP; i++) mst[b][i] = 0;
          mvc[b] = 0;
          if (mwr[b] < WMAX) mwr[b]++;
        end
        default: ;
      endcase
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      mvc[b] = 0; mwr[b] = 0;
      for (int p = 0; p < NP; p++) mst[b][p] = 0;
    end
    #20; rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    sweep("R1");

    issue(0, 0, 0, "R6 read free");
    sweep("R6");

    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) if ((b + p) % 2 == 0) issue(1, b, p, "R2 program");
    sweep("R2");

    issue(1, 1, 1, "R3 program valid");
    issue(1, 2, 0, "R3 program valid");
    sweep("R3");

    issue(3, 0, 0, "R4 invalidate");
    issue(3, 0, 2, "R4 invalidate");
    issue(3, 0, 0, "R4 invalidate invalid");
    issue(3, 0, 1, "R4 invalidate free");
    issue(1, 0, 0, "R3 program invalid");
    issue(0, 0, 0, "R6 read invalid");
    sweep("R4");

    issue(1, 3, 0, "R7 block range");
    issue(1, 0, 6, "R7 page range");
    issue(0, 1, 7, "R7 read range");
    issue(3, 1, 6, "R7 invalidate range");
    issue(2, 3, 0, "R7 erase range");
    sweep("R7");

    issue(2, 0, 7, "R5 erase page ignored");
    sweep("R5");
    issue(1, 0, 0, "R2 program after erase");
    issue(1, 0, 5, "R2 program after erase");
    sweep("R2 reuse");

    for (int i = 0; i < WMAX + 4; i++) issue(2, 2, 0, "R5 wear");
    sweep("R5 saturate");
    issue(1, 2, 3, "R8 back to back");
    issue(0, 2, 3, "R8 back to back");
    sweep("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule